// File: doc/BRIEF.md
# Burst-of-Four Dual-Rate Separate-I/O SRAM Model

This block is a synthesizable model of a small synchronous memory. It has separate read and write ports. Every transfer on either port is a burst of four data beats. The block runs from a clock at twice the external clock rate. One internal cycle carries one beat, so a burst covers two external clock periods. A toggling slot register stands in for the external clock phase. Requests are sampled only at internal edges that correspond to an external rising edge. The two complementary echo strobes show the current phase.

Write beats are gathered into one word four beats wide. That word reaches storage in a single operation on the edge of the last beat. Each beat carries its own byte-lane enables, and lanes that are not enabled keep their old contents.

A read fetches one wide word in a single access and shifts it out one beat per internal cycle. The first beat appears two and a half external clock periods after the request. A write accepted in the same slot as a read, or in an earlier slot, is visible to that read: the gathered word is forwarded lane by lane when its commit coincides with the fetch.

Top module: `sq_burst_sram`

## Requirements
- R1: After reset `rd_valid` is low, `rd_data` is zero and every word reads back as zero on all four beats.
- R2: `ck_echo` toggles on every clock edge after reset and `ck_echo_n` is always its complement. A request is sampled only at an edge that closes a cycle in which `ck_echo` is high; a request held only during a low cycle is dropped.
- R3: A write accepted at edge E takes `wr_data` at E, E+1, E+2 and E+3 as beats 0 to 3 of the addressed word. Beat k is returned as beat k by a later read of the same address.
- R4: Bit l of `wr_be` (1 = write) is sampled with each beat and gates bits [9l+8:9l] of that beat. Lanes and beats that are not enabled keep their previous contents, and an all-zero mask leaves the word unchanged.
- R5: For a read accepted at edge E, beat 0 is on `rd_data` in the cycle after edge E+5, and beats 1, 2 and 3 follow in the next three cycles.
- R6: `rd_valid` is high exactly in the cycles that carry read beats, always in runs that are a multiple of four, and `rd_data` is zero whenever `rd_valid` is low.
- R7: Reads accepted in consecutive allowed slots, four edges apart, give an unbroken eight-beat run on `rd_valid` with the two words in order.
- R8: A read accepted in the same slot as a write to the same address returns the newly written lanes merged with the old ones. A read and a write to different addresses in the same slot both complete.
- R9: A request of either type in the slot right after one of the same type was accepted is ignored: no data appears for it and it writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock at twice the external rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request, sampled in slot cycles |
| rd_addr | input | AW | Word address of the read |
| wr_req | input | 1 | Write request, sampled in slot cycles |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | LANE_W*LANES | Write beat data |
| wr_be | input | LANES | Per-beat lane write enables |
| rd_data | output | LANE_W*LANES | Read beat data, zero when idle |
| rd_valid | output | 1 | High while read beats are driven |
| ck_echo | output | 1 | Phase strobe, high in request slot cycles |
| ck_echo_n | output | 1 | Complement of `ck_echo` |

## Verification
The bench builds the block with the default parameters: 9-bit lanes, four lanes and 64 words. This gives a 36-bit beat and a six-bit address, so the top word 63 and every one of the sixteen lane-beat enables per burst can be reached. With only four lanes, partial masks can be chosen by hand to cover every lane in some beat. The short address also lets same-address collisions, forwarded commits and ignored second requests be set up within a few slots.

// File: rtl/sq_pkg.sv
`timescale 1ns/1ps
package sq_pkg;
   localparam int BEATS     = 4;
   localparam int BEAT_IW   = 2;
   localparam int FETCH_STG = 2;
   localparam int OUT_STG   = 4;
   typedef enum logic {HALF_RISE = 1'b0, HALF_FALL = 1'b1} half_e;
endpackage

// File: rtl/sq_array.sv
`timescale 1ns/1ps
module sq_array #(
   parameter int WORD_W = 144,
   parameter int DEPTH  = 64,
   parameter int AW     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [WORD_W-1:0] wword,
   input  logic [AW-1:0]     raddr_a,
   output logic [WORD_W-1:0] rword_a,
   input  logic [AW-1:0]     raddr_b,
   output logic [WORD_W-1:0] rword_b
);
   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wword;
      end
   end

   assign rword_a = mem[raddr_a];
   assign rword_b = mem[raddr_b];
endmodule

// File: rtl/sq_wr_gather.sv
`timescale 1ns/1ps
module sq_wr_gather
   import sq_pkg::*;
#(
   parameter int LANE_W = 9,
   parameter int LANES  = 4,
   parameter int AW     = 6,
   localparam int DW    = LANE_W * LANES,
   localparam int WW    = DW * BEATS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot,
   input  logic             wr_req,
   input  logic [AW-1:0]    wr_addr,
   input  logic [DW-1:0]    wr_data,
   input  logic [LANES-1:0] wr_be,
   input  logic [WW-1:0]    old_word,
   output logic [AW-1:0]    tgt_addr,
   output logic             commit,
   output logic [WW-1:0]    commit_word
);
   logic               act;
   logic [BEAT_IW-1:0] cnt;
   logic [AW-1:0]      addr_q;
   logic [DW-1:0]      gw [BEATS-1];
   logic [LANES-1:0]   gm [BEATS-1];
   logic               take;

   assign take     = slot && wr_req && !act;
   assign commit   = act && (cnt == BEAT_IW'(BEATS - 1));
   assign tgt_addr = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act    <= 1'b0;
         cnt    <= '0;
         addr_q <= '0;
         for (int b = 0; b < BEATS - 1; b++) begin
            gw[b] <= '0;
            gm[b] <= '0;
         end
      end else if (take) begin
         act    <= 1'b1;
         cnt    <= BEAT_IW'(1);
         addr_q <= wr_addr;
         gw[0]  <= wr_data;
         gm[0]  <= wr_be;
      end else if (act) begin
         if (commit) begin
            act <= 1'b0;
            cnt <= '0;
         end else begin
            cnt <= cnt + BEAT_IW'(1);
            for (int b = 1; b < BEATS - 1; b++) begin
               if (cnt == BEAT_IW'(b)) begin
                  gw[b] <= wr_data;
                  gm[b] <= wr_be;
               end
            end
         end
      end
   end

   // Last beat bypasses the gather registers and merges live.
   for (genvar b = 0; b < BEATS; b++) begin : g_beat
      logic [DW-1:0]    bd;
      logic [LANES-1:0] bm;
      if (b < BEATS - 1) begin : g_held
         assign bd = gw[b];
         assign bm = gm[b];
      end else begin : g_live
         assign bd = wr_data;
         assign bm = wr_be;
      end
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         localparam int LO = b * DW + l * LANE_W;
         assign commit_word[LO +: LANE_W] =
            bm[l] ? bd[l*LANE_W +: LANE_W] : old_word[LO +: LANE_W];
      end
   end
endmodule

// File: rtl/sq_rd_pipe.sv
`timescale 1ns/1ps
module sq_rd_pipe
   import sq_pkg::*;
#(
   parameter int DW = 36,
   parameter int AW = 6,
   localparam int WW = DW * BEATS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          slot,
   input  logic          rd_req,
   input  logic [AW-1:0] rd_addr,
   output logic [AW-1:0] fetch_addr,
   input  logic [WW-1:0] arr_word,
   input  logic          commit,
   input  logic [AW-1:0] commit_addr,
   input  logic [WW-1:0] commit_word,
   output logic [DW-1:0] rd_data,
   output logic          rd_valid
);
   logic [OUT_STG:0]   sv;
   logic [AW-1:0]      sa [FETCH_STG+1];
   logic [WW-1:0]      f_word;
   logic [WW-1:0]      o_word;
   logic [BEAT_IW-1:0] idx;
   logic               take;
   logic               fwd;

   assign take       = slot && rd_req && !sv[1];
   assign fetch_addr = sa[FETCH_STG];
   assign fwd        = commit && (commit_addr == sa[FETCH_STG]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sv <= '0;
         for (int s = 0; s <= FETCH_STG; s++) sa[s] <= '0;
      end else begin
         sv    <= {sv[OUT_STG-1:0], take};
         sa[0] <= rd_addr;
         for (int s = 1; s <= FETCH_STG; s++) sa[s] <= sa[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_word <= '0;
      end else if (sv[FETCH_STG]) begin
         f_word <= fwd ? commit_word : arr_word;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_word   <= '0;
         idx      <= '0;
         rd_valid <= 1'b0;
      end else if (sv[OUT_STG]) begin
         o_word   <= f_word;
         idx      <= '0;
         rd_valid <= 1'b1;
      end else if (rd_valid) begin
         if (idx == BEAT_IW'(BEATS - 1)) rd_valid <= 1'b0;
         idx <= idx + BEAT_IW'(1);
      end
   end

   assign rd_data = rd_valid ? o_word[idx*DW +: DW] : '0;
endmodule

// File: rtl/sq_burst_sram.sv
`timescale 1ns/1ps
module sq_burst_sram
   import sq_pkg::*;
#(
   parameter int LANE_W = 9,
   parameter int LANES  = 4,
   parameter int DEPTH  = 64,
   localparam int DW    = LANE_W * LANES,
   localparam int WW    = DW * BEATS,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_req,
   input  logic [AW-1:0]    rd_addr,
   input  logic             wr_req,
   input  logic [AW-1:0]    wr_addr,
   input  logic [DW-1:0]    wr_data,
   input  logic [LANES-1:0] wr_be,
   output logic [DW-1:0]    rd_data,
   output logic             rd_valid,
   output logic             ck_echo,
   output logic             ck_echo_n
);
   if (LANE_W < 1 || LANES < 1) begin : g_bad_lane
      $error("sq_burst_sram: LANE_W and LANES must be positive");
   end
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("sq_burst_sram: DEPTH must be a power of two, at least 2");
   end

   half_e         half;
   logic          slot;
   logic [AW-1:0] w_tgt, r_tgt;
   logic          w_commit;
   logic [WW-1:0] w_word, w_old, r_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) half <= HALF_RISE;
      else        half <= (half == HALF_RISE) ? HALF_FALL : HALF_RISE;
   end

   assign slot      = (half == HALF_RISE);
   assign ck_echo   = slot;
   assign ck_echo_n = ~slot;

   sq_array #(.WORD_W(WW), .DEPTH(DEPTH), .AW(AW)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (w_commit),
      .waddr   (w_tgt),
      .wword   (w_word),
      .raddr_a (w_tgt),
      .rword_a (w_old),
      .raddr_b (r_tgt),
      .rword_b (r_word)
   );

   sq_wr_gather #(.LANE_W(LANE_W), .LANES(LANES), .AW(AW)) u_wr (
      .clk         (clk),
      .rst_n       (rst_n),
      .slot        (slot),
      .wr_req      (wr_req),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .wr_be       (wr_be),
      .old_word    (w_old),
      .tgt_addr    (w_tgt),
      .commit      (w_commit),
      .commit_word (w_word)
   );

   sq_rd_pipe #(.DW(DW), .AW(AW)) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .slot        (slot),
      .rd_req      (rd_req),
      .rd_addr     (rd_addr),
      .fetch_addr  (r_tgt),
      .arr_word    (r_word),
      .commit      (w_commit),
      .commit_addr (w_tgt),
      .commit_word (w_word),
      .rd_data     (rd_data),
      .rd_valid    (rd_valid)
   );
endmodule

// File: rtl/sq_burst_sram_chk.sv
`timescale 1ns/1ps
module sq_burst_sram_chk #(
   parameter int DW = 36
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_req,
   input logic          ck_echo,
   input logic          ck_echo_n,
   input logic          rd_valid,
   input logic [DW-1:0] rd_data
);
   logic [1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_q <= '0;
      else if (rd_valid) run_q <= run_q + 2'd1;
      else               run_q <= '0;
   end

   AST_ECHO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (ck_echo != $past(ck_echo)));                      // R2
   AST_ECHO_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      ck_echo_n == !ck_echo);                                      // R2
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_data == '0));                              // R6
   AST_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_valid) |-> (run_q == 2'd0));                        // R6
   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> $past(rd_req && ck_echo, 6));            // R5
endmodule

bind sq_burst_sram sq_burst_sram_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_req    (rd_req),
   .ck_echo   (ck_echo),
   .ck_echo_n (ck_echo_n),
   .rd_valid  (rd_valid),
   .rd_data   (rd_data)
);

// File: tb/sq_burst_sram_test.sv
`timescale 1ns/1ps
module sq_burst_sram_test;
   localparam int DW = 36;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_req = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          wr_req = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [3:0]    wr_be = '0;
   logic [DW-1:0] rd_data;
   logic          rd_valid;
   logic          ck_echo, ck_echo_n;

   int  n_run = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   logic [DW-1:0] model [64][4];

   // {addr, seed, mask}: mask bits [4k+3:4k] are the lane enables of beat k
   localparam logic [57:0] VECS [6] = '{
      {6'd0,  36'h123456789, 16'hFFFF},
      {6'd5,  36'hA5A5A5A5A, 16'hFFFF},
      {6'd63, 36'h0FEDCBA98, 16'hFFFF},
      {6'd5,  36'h333333333, 16'h000F},
      {6'd5,  36'h9C9C9C9C9, 16'h5A3C},
      {6'd12, 36'h777777777, 16'h0000}
   };

   always #4 clk = ~clk;

   sq_burst_sram uut (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
      .rd_data(rd_data), .rd_valid(rd_valid), .ck_echo(ck_echo),
      .ck_echo_n(ck_echo_n)
   );

   function automatic logic [DW-1:0] beat_of(logic [DW-1:0] s, int k);
      return s + (36'h111111111 * 36'(k));
   endfunction

   task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_slot();
      @(negedge clk);
      while (!ck_echo) @(negedge clk);
   endtask

   task automatic wr_burst(logic [AW-1:0] a, logic [DW-1:0] seed, logic [15:0] m);
      for (int k = 0; k < 4; k++)
         for (int l = 0; l < 4; l++)
            if (m[4*k+l]) model[a][k][9*l +: 9] = beat_of(seed, k)[9*l +: 9];
      wr_req  = 1'b1;
      wr_addr = a;
      for (int k = 0; k < 4; k++) begin
         wr_data = beat_of(seed, k);
         wr_be   = m[4*k +: 4];
         @(negedge clk);
         wr_req = 1'b0;
      end
      wr_data = '0;
      wr_be   = '0;
   endtask

   task automatic rd_check(logic [AW-1:0] a, bit pre, string req);
      rd_req  = 1'b1;
      rd_addr = a;
      @(negedge clk);
      rd_req = 1'b0;
      repeat (4) @(negedge clk);
      if (pre) chk(rd_valid == 1'b0, {req, " R5 early valid"}, DW'(rd_valid), '0);
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
         chk(rd_valid == 1'b1, {req, " R6 valid"}, DW'(rd_valid), 36'd1);
         chk(rd_data == model[a][k], {req, " R5 beat"}, rd_data, model[a][k]);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog expired actual=%h expected=%h", 36'd0, 36'd1);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < 64; a++)
         for (int k = 0; k < 4; k++) model[a][k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(rd_valid == 1'b0, "R1 valid after reset", DW'(rd_valid), '0);
      chk(rd_data == '0, "R1 data after reset", rd_data, '0);
      // R2: echo strobes complementary and toggling
      for (int i = 0; i < 4; i++) begin
         logic prev;
         prev = ck_echo;
         chk(ck_echo_n == !ck_echo, "R2 echo pair", DW'(ck_echo_n), DW'(!ck_echo));
         @(negedge clk);
         chk(ck_echo != prev, "R2 echo toggle", DW'(ck_echo), DW'(!prev));
      end
      wait_slot();
      rd_check(6'd40, 1'b1, "R1 unwritten word");

      // Vector table: write then read back
      for (int v = 0; v < 6; v++) begin
         wait_slot();
         wr_burst(VECS[v][57:52], VECS[v][51:16], VECS[v][15:0]);
         wait_slot();
         rd_check(VECS[v][57:52], 1'b1, "R3 R4 vector");
      end

      // R2: request held only in a non-slot cycle is dropped
      wait_slot();
      @(negedge clk);
      rd_req = 1'b1; rd_addr = 6'd5;
      @(negedge clk);
      rd_req = 1'b0;
      for (int i = 0; i < 10; i++) begin
         chk(rd_valid == 1'b0, "R2 off-slot read dropped", DW'(rd_valid), '0);
         @(negedge clk);
      end

      // R8: same-slot read and write to one address, partial mask
      wait_slot();
      fork
         wr_burst(6'd5, 36'h2468ACE13, 16'hC3A5);
         rd_check(6'd5, 1'b1, "R8 same-address coherence");
      join

      // R8: same slot, different addresses
      wait_slot();
      fork
         wr_burst(6'd8, 36'h0BADF00D1, 16'hFFFF);
         rd_check(6'd63, 1'b1, "R8 independent ports");
      join
      wait_slot();
      rd_check(6'd8, 1'b1, "R8 independent write landed");

      // R9: second write in the next slot is ignored
      wait_slot();
      fork
         wr_burst(6'd20, 36'h55AA55AA5, 16'hFFFF);
         begin
            repeat (2) @(negedge clk);
            wr_req = 1'b1; wr_addr = 6'd21;
            @(negedge clk);
            wr_req = 1'b0;
         end
      join
      wait_slot();
      rd_check(6'd21, 1'b1, "R9 ignored write left word");
      wait_slot();
      rd_check(6'd20, 1'b1, "R9 first write kept");

      // R9: second read in the next slot is ignored
      wait_slot();
      fork
         rd_check(6'd20, 1'b1, "R9 first read");
         begin
            repeat (2) @(negedge clk);
            rd_req = 1'b1; rd_addr = 6'd63;
            @(negedge clk);
            rd_req = 1'b0;
         end
      join
      for (int i = 0; i < 3; i++) begin
         chk(rd_valid == 1'b0, "R9 ignored read gave no data", DW'(rd_valid), '0);
         @(negedge clk);
      end

      // R7: back-to-back reads every other slot
      wait_slot();
      fork
         rd_check(6'd0, 1'b1, "R7 first");
         begin
            repeat (4) @(negedge clk);
            rd_check(6'd63, 1'b0, "R7 second");
         end
      join
      chk(rd_valid == 1'b0, "R7 run ends after eight beats", DW'(rd_valid), '0);
      chk(rd_data == '0, "R6 idle data zero", rd_data, '0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule